// File: doc/BRIEF.md
# Page-Table Refill Walker

This block fills the translation buffer after a miss. It takes a faulting virtual address and works out where the matching page-table entry sits. The table lives in a virtual region, so the block asks the translation buffer to map that entry address. This inner lookup acts as a privilege-0 data load and never starts a walk of its own. The block then reads one word from memory at the physical address it got back and splits the word into fields. Last, it installs the mapping in one of four refill ways, picked in rotation.

The walk has only one level. When the inner lookup fails, or the read comes back with a bus error, the walk ends and reports the original miss. A probe request follows the same path but leaves the translation buffer, the way rotation and the fault-address register as they were. It returns the translation on the completion outputs.

Top module: `ptw_refill`

## Requirements
- R1: After synchronous reset, `busy`, `lkp_valid`, `mem_req_valid`, `tlbw_en` and `done_valid` are 0, `excvaddr` is 0 and the way rotation restarts, so the first refill after reset uses way 1.
- R2: In the cycle after a request is accepted, `lkp_valid` is high for exactly one cycle. `lkp_vaddr` then equals `(ptbase | (miss_vaddr >> 10)) & ~3`.
- R3: If the inner lookup reports no usable mapping, no memory read and no buffer write follow, and completion signals a fault whose cause is the original miss: 1 for an instruction-fetch miss, 2 for a data miss (0 means no fault).
- R4: After a lookup hit, `mem_req_valid` rises with `mem_req_addr` equal to `lkp_paddr`. The request is held, with the address stable, until the cycle in which `mem_req_ready` is high.
- R5: A response with `mem_rsp_err` set ends the walk with the original-miss fault and no buffer write.
- R6: A successful non-probe walk pulses `tlbw_en` for one cycle. In that cycle `tlbw_vpn` is the faulting address bits 31:12, `tlbw_ppn` is entry bits 31:12, `tlbw_ring` is entry bits 5:4, `tlbw_attr` is entry bits 3:0, and `tlbw_dside` is the inverse of the fetch flag.
- R7: The 2-bit refill way counter advances before each refill, so successive refills use ways 1, 2, 3, 0, 1 and so on. Probes and failed walks do not advance it.
- R8: `excvaddr` takes the faulting virtual address after a successful refill, and keeps its value in every other case.
- R9: A probe that succeeds writes nothing. Completion returns `done_paddr = {entry[31:12], vaddr[11:0]}`, the ring and the attribute, with `done_fault` low.
- R10: `busy` is high from the cycle after acceptance up to and including the completion cycle. A request raised while busy is ignored.
- R11: Each accepted request produces exactly one single-cycle `done_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request; accepted while not busy |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_fetch | input | 1 | 1 for an instruction-fetch miss, 0 for a data miss |
| miss_probe | input | 1 | Probe only; no state update |
| ptbase | input | 32 | Page-table base register value |
| lkp_valid | output | 1 | Inner lookup request (privilege-0 data load, no walk) |
| lkp_vaddr | output | 32 | Page-table entry virtual address |
| lkp_ok | input | 1 | Inner lookup hit with load permission |
| lkp_paddr | input | 32 | Physical address from the inner lookup |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Memory read address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read response bus error |
| mem_rsp_data | input | 32 | Fetched page-table entry |
| tlbw_en | output | 1 | Buffer write strobe |
| tlbw_dside | output | 1 | 1 writes the data-side buffer, 0 the fetch side |
| tlbw_way | output | 2 | Refill way |
| tlbw_vpn | output | 20 | Virtual page number |
| tlbw_ppn | output | 20 | Physical page number |
| tlbw_ring | output | 2 | Ring of the new mapping |
| tlbw_attr | output | 4 | Attribute of the new mapping |
| excvaddr | output | 32 | Exception virtual address register |
| busy | output | 1 | Walk in progress |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Walk failed |
| done_cause | output | 2 | 0 none, 1 fetch miss, 2 data miss |
| done_paddr | output | 32 | Translated physical address |
| done_ring | output | 2 | Ring from the entry |
| done_attr | output | 4 | Attribute from the entry |
| done_pte | output | 32 | Raw fetched entry |

## Verification
A bad rotation counter shows up on `tlbw_way` at the very next refill. A probe or fault that wrongly advanced it is caught on the following refill, so the vectors mix probes and faults in between refills. A wrong state transition shows within a few cycles: a missing or extra read request, a write after a fault, or a completion pulse that never comes. A fault-address register updated on the wrong path is exposed by reading `excvaddr` after every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XLATE = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } walk_st_e;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_IMISS = 2'd1;
  localparam logic [1:0] CAUSE_DMISS = 2'd2;

  localparam int RING_LSB = 4;
  localparam int RING_W   = 2;
  localparam int ATTR_W   = 4;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LOG2   = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] vaddr,
  output logic [VA_W-1:0] pte_vaddr
);
  localparam int SHIFT = PAGE_SHIFT - PTE_LOG2;
  localparam logic [VA_W-1:0] ALIGN_MASK = {{(VA_W-PTE_LOG2){1'b1}}, {PTE_LOG2{1'b0}}};

  always_comb begin
    pte_vaddr = (base | (vaddr >> SHIFT)) & ALIGN_MASK;
  end
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [WAY_W-1:0] next_way
);
  logic [WAY_W-1:0] ctr_q;

  always_comb begin
    next_way = ctr_q + WAY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
    end else if (advance) begin
      ctr_q <= next_way;
    end
  end
endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
  import ptw_pkg::*;
#(
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [PA_W-1:0]            pte,
  output logic [PA_W-PAGE_SHIFT-1:0] ppn,
  output logic [RING_W-1:0]          ring,
  output logic [ATTR_W-1:0]          attr
);
  always_comb begin
    ppn  = pte[PA_W-1:PAGE_SHIFT];
    ring = pte[RING_LSB +: RING_W];
    attr = pte[ATTR_W-1:0];
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            miss_valid,
  input  logic [VA_W-1:0] miss_vaddr,
  input  logic            miss_fetch,
  input  logic            miss_probe,
  input  logic [VA_W-1:0] pte_vaddr_in,
  input  logic            lkp_ok,
  input  logic [PA_W-1:0] lkp_paddr,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [PA_W-1:0] mem_rsp_data,
  output logic            lkp_valid,
  output logic [VA_W-1:0] lkp_vaddr,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  output logic            refill_fire,
  output logic [VA_W-1:0] va_out,
  output logic            fetch_out,
  output logic [PA_W-1:0] pte_out,
  output logic [VA_W-1:0] excvaddr,
  output logic            busy,
  output logic            done_valid,
  output logic            done_fault,
  output logic [1:0]      done_cause
);
  walk_st_e        st_q;
  logic [VA_W-1:0] va_q;
  logic [VA_W-1:0] ptva_q;
  logic [PA_W-1:0] pa_q;
  logic [PA_W-1:0] pte_q;
  logic [VA_W-1:0] excv_q;
  logic            fetch_q;
  logic            probe_q;
  logic            req_pend_q;
  logic            fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      ptva_q     <= '0;
      pa_q       <= '0;
      pte_q      <= '0;
      excv_q     <= '0;
      fetch_q    <= 1'b0;
      probe_q    <= 1'b0;
      req_pend_q <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (miss_valid) begin
            va_q    <= miss_vaddr;
            fetch_q <= miss_fetch;
            probe_q <= miss_probe;
            ptva_q  <= pte_vaddr_in;
            fault_q <= 1'b0;
            st_q    <= ST_XLATE;
          end
        end
        ST_XLATE: begin
          if (lkp_ok) begin
            pa_q       <= lkp_paddr;
            req_pend_q <= 1'b1;
            st_q       <= ST_READ;
          end else begin
            fault_q <= 1'b1;
            st_q    <= ST_DONE;
          end
        end
        ST_READ: begin
          if (req_pend_q) begin
            if (mem_req_ready) begin
              req_pend_q <= 1'b0;
            end
          end else if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              fault_q <= 1'b1;
              st_q    <= ST_DONE;
            end else begin
              pte_q <= mem_rsp_data;
              st_q  <= probe_q ? ST_DONE : ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          excv_q <= va_q;
          st_q   <= ST_DONE;
        end
        ST_DONE: begin
          st_q <= ST_IDLE;
        end
        default: begin
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    busy          = (st_q != ST_IDLE);
    lkp_valid     = (st_q == ST_XLATE);
    lkp_vaddr     = ptva_q;
    mem_req_valid = (st_q == ST_READ) && req_pend_q;
    mem_req_addr  = pa_q;
    refill_fire   = (st_q == ST_WRITE);
    done_valid    = (st_q == ST_DONE);
    done_fault    = fault_q;
    done_cause    = fault_q ? (fetch_q ? CAUSE_IMISS : CAUSE_DMISS) : CAUSE_NONE;
    va_out        = va_q;
    fetch_out     = fetch_q;
    pte_out       = pte_q;
    excvaddr      = excv_q;
  end
endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LOG2   = 2,
  parameter int WAYS       = 4,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic             miss_fetch,
  input  logic             miss_probe,
  input  logic [VA_W-1:0]  ptbase,
  output logic             lkp_valid,
  output logic [VA_W-1:0]  lkp_vaddr,
  input  logic             lkp_ok,
  input  logic [PA_W-1:0]  lkp_paddr,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             tlbw_en,
  output logic             tlbw_dside,
  output logic [WAY_W-1:0] tlbw_way,
  output logic [VPN_W-1:0] tlbw_vpn,
  output logic [PPN_W-1:0] tlbw_ppn,
  output logic [RING_W-1:0] tlbw_ring,
  output logic [ATTR_W-1:0] tlbw_attr,
  output logic [VA_W-1:0]  excvaddr,
  output logic             busy,
  output logic             done_valid,
  output logic             done_fault,
  output logic [1:0]       done_cause,
  output logic [PA_W-1:0]  done_paddr,
  output logic [RING_W-1:0] done_ring,
  output logic [ATTR_W-1:0] done_attr,
  output logic [PA_W-1:0]  done_pte
);
  logic [VA_W-1:0]   pte_vaddr;
  logic              refill_fire;
  logic [VA_W-1:0]   va_cur;
  logic              fetch_cur;
  logic [PA_W-1:0]   pte_cur;
  logic [PPN_W-1:0]  ppn_dec;
  logic [RING_W-1:0] ring_dec;
  logic [ATTR_W-1:0] attr_dec;

  ptw_addr_gen #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PTE_LOG2(PTE_LOG2)
  ) addr_i (
    .base(ptbase), .vaddr(miss_vaddr), .pte_vaddr(pte_vaddr)
  );

  ptw_walk_fsm #(
    .VA_W(VA_W), .PA_W(PA_W)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_fetch(miss_fetch), .miss_probe(miss_probe),
    .pte_vaddr_in(pte_vaddr),
    .lkp_ok(lkp_ok), .lkp_paddr(lkp_paddr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .refill_fire(refill_fire), .va_out(va_cur), .fetch_out(fetch_cur),
    .pte_out(pte_cur), .excvaddr(excvaddr), .busy(busy),
    .done_valid(done_valid), .done_fault(done_fault), .done_cause(done_cause)
  );

  ptw_way_ctr #(.WAYS(WAYS)) way_i (
    .clk(clk), .rst(rst), .advance(refill_fire), .next_way(tlbw_way)
  );

  ptw_pte_dec #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) dec_i (
    .pte(pte_cur), .ppn(ppn_dec), .ring(ring_dec), .attr(attr_dec)
  );

  always_comb begin
    tlbw_en    = refill_fire;
    tlbw_dside = ~fetch_cur;
    tlbw_vpn   = va_cur[VA_W-1:PAGE_SHIFT];
    tlbw_ppn   = ppn_dec;
    tlbw_ring  = ring_dec;
    tlbw_attr  = attr_dec;
    done_paddr = {ppn_dec, va_cur[PAGE_SHIFT-1:0]};
    done_ring  = ring_dec;
    done_attr  = attr_dec;
    done_pte   = pte_cur;
  end
endmodule

// File: rtl/ptw_refill_chk.sv
module ptw_refill_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             lkp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             tlbw_en,
  input logic [WAY_W-1:0] tlbw_way,
  input logic [VA_W-1:0]  excvaddr,
  input logic             done_valid,
  input logic             done_fault,
  input logic [1:0]       done_cause
);
  logic [WAY_W-1:0] last_way;

  always_ff @(posedge clk) begin
    if (rst) last_way <= '0;
    else if (tlbw_en) last_way <= tlbw_way;
  end

  AST_LKP_PULSE: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> !lkp_valid); // R2
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> (done_cause != 2'd0)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault) |-> !$past(tlbw_en)); // R5
  AST_WAY_ROTATE: assert property (@(posedge clk) disable iff (rst)
    tlbw_en |-> (tlbw_way == WAY_W'(last_way + WAY_W'(1)))); // R7
  AST_EXCV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tlbw_en |=> $stable(excvaddr)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!lkp_valid && !mem_req_valid && !tlbw_en && !done_valid)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R11
endmodule

bind ptw_refill ptw_refill_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .WAY_W(WAY_W)
) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .lkp_valid(lkp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .tlbw_en(tlbw_en), .tlbw_way(tlbw_way),
  .excvaddr(excvaddr), .done_valid(done_valid), .done_fault(done_fault),
  .done_cause(done_cause)
);

// File: tb/ptw_refill_tb.sv
module ptw_refill_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        miss_fetch = 1'b0;
  logic        miss_probe = 1'b0;
  logic [31:0] ptbase = '0;
  logic        lkp_valid;
  logic [31:0] lkp_vaddr;
  logic        lkp_ok;
  logic [31:0] lkp_paddr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tlbw_en, tlbw_dside;
  logic [1:0]  tlbw_way;
  logic [19:0] tlbw_vpn, tlbw_ppn;
  logic [1:0]  tlbw_ring;
  logic [3:0]  tlbw_attr;
  logic [31:0] excvaddr;
  logic        busy, done_valid, done_fault;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr;
  logic [1:0]  done_ring;
  logic [3:0]  done_attr;
  logic [31:0] done_pte;

  logic        tb_lok = 1'b0;
  logic [31:0] tb_lpa = '0;
  assign lkp_ok    = lkp_valid & tb_lok;
  assign lkp_paddr = tb_lpa;

  always #4 clk = ~clk;

  ptw_refill dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_fetch(miss_fetch), .miss_probe(miss_probe), .ptbase(ptbase),
    .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr), .lkp_ok(lkp_ok),
    .lkp_paddr(lkp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_data(mem_rsp_data), .tlbw_en(tlbw_en), .tlbw_dside(tlbw_dside),
    .tlbw_way(tlbw_way), .tlbw_vpn(tlbw_vpn), .tlbw_ppn(tlbw_ppn),
    .tlbw_ring(tlbw_ring), .tlbw_attr(tlbw_attr), .excvaddr(excvaddr),
    .busy(busy), .done_valid(done_valid), .done_fault(done_fault),
    .done_cause(done_cause), .done_paddr(done_paddr), .done_ring(done_ring),
    .done_attr(done_attr), .done_pte(done_pte)
  );

  typedef struct packed {
    logic        fetch;
    logic        probe;
    logic [31:0] va;
    logic [31:0] ptb;
    logic        lok;
    logic [31:0] lpa;
    logic        err;
    logic [31:0] pte;
    logic [3:0]  dly;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 32'h12345678, 32'h80000000, 1'b1, 32'h00048D14, 1'b0, 32'hABCDE035, 4'd0},
    '{1'b1, 1'b0, 32'h00401ABC, 32'hC0000000, 1'b1, 32'h10001004, 1'b0, 32'h11111013, 4'd2},
    '{1'b0, 1'b1, 32'hFFFFF000, 32'h00000000, 1'b1, 32'h00002000, 1'b0, 32'h7777702F, 4'd1},
    '{1'b1, 1'b0, 32'h50000000, 32'h40000000, 1'b0, 32'h00000000, 1'b0, 32'h00000000, 4'd0},
    '{1'b0, 1'b0, 32'h0BAD0123, 32'h90000000, 1'b1, 32'h00000030, 1'b1, 32'hFFFFFFFF, 4'd3},
    '{1'b0, 1'b0, 32'h89ABCDEF, 32'h00000003, 1'b1, 32'h00000444, 1'b0, 32'h00001026, 4'd0},
    '{1'b1, 1'b0, 32'h33333333, 32'hF0000000, 1'b1, 32'h55550000, 1'b0, 32'hFEDCB00E, 4'd0},
    '{1'b0, 1'b0, 32'h70000004, 32'hA0000000, 1'b1, 32'h00001110, 1'b0, 32'h12340010, 4'd1}
  };

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0]  m_ctr = 2'd0;
  logic [31:0] m_excv = '0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v, input logic hold);
    logic [31:0] exp_ptva;
    logic        exp_fault, exp_wr;
    logic [1:0]  exp_cause;
    int dones, wrs, req_cyc, wait_n;
    bit mem_seen, rsp_sent, got_done;
    logic [31:0] seen_addr;
    logic [19:0] w_vpn, w_ppn;
    logic [1:0]  w_way, w_ring;
    logic [3:0]  w_attr;
    logic        w_dside, d_fault;
    logic [1:0]  d_cause, d_ring;
    logic [31:0] d_paddr;
    logic [3:0]  d_attr;
    exp_ptva  = (v.ptb | (v.va >> 10)) & 32'hFFFFFFFC;
    exp_fault = !v.lok || v.err;
    exp_wr    = !exp_fault && !v.probe;
    exp_cause = exp_fault ? (v.fetch ? 2'd1 : 2'd2) : 2'd0;
    dones = 0; wrs = 0; req_cyc = 0; wait_n = 0;
    mem_seen = 0; rsp_sent = 0; got_done = 0; seen_addr = '0;
    w_vpn = '0; w_ppn = '0; w_way = '0; w_ring = '0; w_attr = '0; w_dside = 0;
    d_fault = 0; d_cause = '0; d_ring = '0; d_paddr = '0; d_attr = '0;
    tb_lok = v.lok; tb_lpa = v.lpa;
    mem_rsp_data = v.pte; mem_rsp_err = v.err;
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = v.va; miss_fetch = v.fetch;
    miss_probe = v.probe; ptbase = v.ptb;
    @(negedge clk);
    miss_valid = hold;
    if (hold) miss_vaddr = 32'hDEAD0000;
    chk("R10 busy after accept", busy, 1);
    chk("R2 lookup valid", lkp_valid, 1);
    chk("R2 lookup address", lkp_vaddr, exp_ptva);
    for (int c = 0; c < 60 && !got_done; c++) begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (done_valid) begin
        dones++; got_done = 1;
        d_fault = done_fault; d_cause = done_cause; d_paddr = done_paddr;
        d_ring = done_ring; d_attr = done_attr;
        miss_valid = 1'b0;
      end
      if (tlbw_en) begin
        wrs++; w_vpn = tlbw_vpn; w_ppn = tlbw_ppn; w_way = tlbw_way;
        w_ring = tlbw_ring; w_attr = tlbw_attr; w_dside = tlbw_dside;
      end
      if (mem_req_valid) begin
        mem_seen = 1; req_cyc++; seen_addr = mem_req_addr;
        if (wait_n >= int'(v.dly)) mem_req_ready = 1'b1;
        wait_n++;
      end else if (mem_seen && !rsp_sent) begin
        mem_rsp_valid = 1'b1; rsp_sent = 1;
      end
    end
    miss_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle after done", busy, 0);
    chk("R11 single done pulse", done_valid, 0);
    chk("R11 done count", dones, 1);
    if (!v.lok) begin
      chk("R3 no memory read on inner miss", mem_seen, 0);
    end else begin
      chk("R4 read address", seen_addr, v.lpa);
      chk("R4 request held until ready", req_cyc, int'(v.dly) + 1);
    end
    chk(v.err ? "R5 fault on bus error" : "R3 fault flag", d_fault, exp_fault);
    chk(v.err ? "R5 fault cause" : "R3 fault cause", d_cause, exp_cause);
    chk(v.probe ? "R9 probe writes nothing" : "R6 write count", wrs, exp_wr ? 1 : 0);
    if (exp_wr) begin
      m_ctr = m_ctr + 2'd1;
      m_excv = v.va;
      chk("R7 refill way", w_way, m_ctr);
      chk("R6 vpn", w_vpn, v.va[31:12]);
      chk("R6 ppn", w_ppn, v.pte[31:12]);
      chk("R6 ring", w_ring, v.pte[5:4]);
      chk("R6 attr", w_attr, v.pte[3:0]);
      chk("R6 side", w_dside, !v.fetch);
    end
    if (!exp_fault) begin
      chk(v.probe ? "R9 probe paddr" : "R6 done paddr", d_paddr, {v.pte[31:12], v.va[11:0]});
      chk(v.probe ? "R9 probe ring" : "R6 done ring", d_ring, v.pte[5:4]);
      chk(v.probe ? "R9 probe attr" : "R6 done attr", d_attr, v.pte[3:0]);
    end
    chk("R8 exception vaddr", excvaddr, m_excv);
  endtask

  task automatic check_reset_state();
    chk("R1 busy", busy, 0);
    chk("R1 lookup", lkp_valid, 0);
    chk("R1 mem request", mem_req_valid, 0);
    chk("R1 write", tlbw_en, 0);
    chk("R1 done", done_valid, 0);
    chk("R1 excvaddr", excvaddr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      run_txn(VECS[i], 1'b0);
    end

    // R10: a second request held high during a walk is ignored
    run_txn('{1'b0, 1'b0, 32'h2468ACE0, 32'h60000000, 1'b1, 32'h00000800, 1'b0, 32'hCAFEB025, 4'd1}, 1'b1);
    @(negedge clk);
    chk("R10 no walk from ignored request", busy, 0);

    // R1: reset mid-life restarts the rotation and clears the register
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();
    m_ctr = 2'd0;
    m_excv = '0;
    run_txn('{1'b1, 1'b0, 32'h00010000, 32'h00400000, 1'b1, 32'h00000100, 1'b0, 32'h0000A03F, 4'd0}, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule